// File: doc/BRIEF.md
# Mailbox Doorbell Register Bank

This block is the register front end of a shared-memory mailbox between peers. A host reaches it through a small 32-bit register bus. It holds an interrupt mask, an interrupt status word and a read-only position word that reports this node's own index. It also has a write-only doorbell that sends a notification to another peer.

A doorbell write packs a destination peer and a vector number into one data word. The block checks the pair against a per-peer table that records how many vectors each peer has registered. A legal pair raises a one-cycle notify pulse, with the peer and vector alongside it. An illegal pair is dropped and nothing is reported. The table is loaded through a separate configuration port, one entry per peer index.

An incoming event for this node overwrites the status word with 1. The level interrupt output is high while any bit is set in both status and mask.

Top module: `mbox_doorbell_regs`

## Requirements
- R1: After reset, mask and status read 0, `irq_o` is 0, `notify_o` is 0, and every entry of the vector-count table is 0.
- R2: Mask (offset 0x00) and status (offset 0x04) are full 32-bit read/write registers. Offset 0x08 reads `pos_i` zero-extended to 32 bits. Read data and `rvalid_o` appear in the cycle after the request.
- R3: Writes decode the address with its two low bits forced to zero. A write to 0x03 therefore lands in mask, and a write to 0x06 lands in status.
- R4: Reads decode the full 8-bit address. Any read address other than exactly 0x00, 0x04 or 0x08 returns 0, and this includes unaligned addresses and the doorbell offset 0x0C. A read of any offset other than exactly 0x04 leaves status unchanged.
- R5: Writes to 0x08 or to any offset with no register leave mask and status unchanged.
- R6: A read of status returns the current value and clears status to 0 in the same access.
- R7: An event on `event_i` sets status to exactly 1, discarding the previous contents. It takes priority over a software write or a read-clear of status in the same cycle, and a read in that cycle still returns the old value.
- R8: `irq_o` is the OR over all bits of (status AND mask).
- R9: A write to 0x0C is a doorbell. The destination peer is taken from data bits 31:16 and the vector from bits 7:0; bits 15:8 are ignored. A legal doorbell drives `notify_o` high for exactly the next cycle, with `notify_peer_o` and `notify_vec_o` carrying the two fields.
- R10: A doorbell whose peer is at or above `NUM_PEERS` produces no notify.
- R11: A doorbell whose vector is at or above the table count of its peer produces no notify. A table entry is written when `cfg_we_i` is high, and the new count applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address in the 256-byte window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pos_i | input | 16 | This node's own peer index |
| event_i | input | 1 | Incoming event for this node |
| irq_o | output | 1 | Level interrupt |
| cfg_we_i | input | 1 | Vector-count table write strobe |
| cfg_peer_i | input | $clog2(NUM_PEERS) | Table entry index |
| cfg_count_i | input | 9 | Number of registered vectors for that peer (0..256) |
| notify_o | output | 1 | One-cycle doorbell notify pulse |
| notify_peer_o | output | 16 | Destination peer of the notify |
| notify_vec_o | output | 8 | Vector of the notify |

## Verification
The bench sweeps every peer from 0 to two past the peer count, and every vector from 0 to past the largest table count. A filler pattern sits in bits 15:8 of each doorbell word. This exposes an off-by-one in either range check, since such a design would notify at the boundary vector or peer, and it exposes a design that takes the vector from the wrong bits. Each notify is followed by a check that the pulse lasts one cycle.

The bench also covers the asymmetric address decode. A design that masked read addresses would return mask data at 0x01. A design that ignored the low bits on reads would clear status through a read of 0x05. Same-cycle collisions of an event with a status write or a status read show whether the event wins, and whether the read returns the old value. A design that OR-ed events into status would read back more than 1.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PEER_W = 16;
  localparam int VEC_W  = 8;
  localparam int CNT_W  = VEC_W + 1;

  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_POS  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_BELL = 8'h0C;

  localparam int BELL_PEER_LSB = 16;
endpackage

// File: rtl/mbox_vec_table.sv
module mbox_vec_table #(
  parameter int NUM_PEERS = 16,
  parameter int IDX_W     = $clog2(NUM_PEERS),
  parameter int CNT_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[g] <= '0;
      else if (cfg_we_i && cfg_idx_i == IDX_W'(g)) cnt_q[g] <= cfg_cnt_i;
    end
  end

  always_comb begin
    rd_cnt_o = '0;
    for (int i = 0; i < NUM_PEERS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_cnt_o = cnt_q[i];
  end

  a_r11_cfg_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !(rd_idx_i != cfg_idx_i) && 32'(cfg_idx_i) < NUM_PEERS)
      |=> rd_cnt_o == $past(cfg_cnt_i) || $past(rd_idx_i) != rd_idx_i || cfg_we_i);
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int IDX_W     = $clog2(NUM_PEERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [PEER_W-1:0] peer_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [IDX_W-1:0]  tbl_idx_o,
  input  logic [CNT_W-1:0]  tbl_cnt_i,
  output logic              notify_o,
  output logic [PEER_W-1:0] peer_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam logic [PEER_W-1:0] NP = PEER_W'(NUM_PEERS);

  logic peer_ok, vec_ok;

  assign tbl_idx_o = peer_i[IDX_W-1:0];
  assign peer_ok   = peer_i < NP;
  assign vec_ok    = {1'b0, vec_i} < tbl_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_o <= 1'b0;
      peer_o   <= '0;
      vec_o    <= '0;
    end else begin
      notify_o <= fire_i && peer_ok && vec_ok;
      if (fire_i) begin
        peer_o <= peer_i;
        vec_o  <= vec_i;
      end
    end
  end

  a_r9_notify_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> $past(fire_i));
  a_r10_peer_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> peer_o < NP);
  a_r9_fields_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> peer_o == $past(peer_i) && vec_o == $past(vec_i));
endmodule

// File: rtl/mbox_doorbell_regs.sv
module mbox_doorbell_regs
  import mbox_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  localparam int IDX_W    = $clog2(NUM_PEERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic [PEER_W-1:0] pos_i,
  input  logic              event_i,
  output logic              irq_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_peer_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  output logic              notify_o,
  output logic [PEER_W-1:0] notify_peer_o,
  output logic [VEC_W-1:0]  notify_vec_o
);
  logic [DATA_W-1:0] mask_q, status_q;
  logic [ADDR_W-1:0] waddr;
  logic              wr, rd, bell_fire;
  logic [IDX_W-1:0]  tbl_idx;
  logic [CNT_W-1:0]  tbl_cnt;

  assign wr        = req_i && we_i;
  assign rd        = req_i && !we_i;
  assign waddr     = {addr_i[ADDR_W-1:2], 2'b00};
  assign bell_fire = wr && waddr == OFF_BELL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr && waddr == OFF_MASK) mask_q <= wdata_i;
  end

  // event beats software; read-clear uses the exact address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         status_q <= '0;
    else if (event_i)                    status_q <= DATA_W'(1);
    else if (wr && waddr == OFF_STAT)    status_q <= wdata_i;
    else if (rd && addr_i == OFF_STAT)   status_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) begin
        unique case (addr_i)
          OFF_MASK: rdata_o <= mask_q;
          OFF_STAT: rdata_o <= status_q;
          OFF_POS:  rdata_o <= DATA_W'(pos_i);
          default:  rdata_o <= '0;
        endcase
      end else begin
        rdata_o <= '0;
      end
    end
  end

  assign irq_o = |(status_q & mask_q);

  mbox_vec_table #(.NUM_PEERS(NUM_PEERS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_idx_i (cfg_peer_i),
    .cfg_cnt_i (cfg_count_i),
    .rd_idx_i  (tbl_idx),
    .rd_cnt_o  (tbl_cnt)
  );

  mbox_doorbell #(.NUM_PEERS(NUM_PEERS), .IDX_W(IDX_W)) u_bell (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (bell_fire),
    .peer_i    (wdata_i[BELL_PEER_LSB +: PEER_W]),
    .vec_i     (wdata_i[VEC_W-1:0]),
    .tbl_idx_o (tbl_idx),
    .tbl_cnt_i (tbl_cnt),
    .notify_o  (notify_o),
    .peer_o    (notify_peer_o),
    .vec_o     (notify_vec_o)
  );

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFF_STAT && !event_i) |=> status_q == '0);
  a_r7_event_sets_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> status_q == DATA_W'(1));
  a_r5_pos_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && waddr == OFF_POS && !event_i) |=> $stable(mask_q) && $stable(status_q));
  a_r2_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(rd));
endmodule

// File: tb/sim_mbox_doorbell_regs.sv
`timescale 1ns/1ps
module sim_mbox_doorbell_regs;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ev = 1'b0, cfg_we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pos = 16'h00A7;
  logic [1:0]  cfg_peer = '0;
  logic [8:0]  cfg_cnt = '0;
  logic [31:0] rdata;
  logic        rvalid, irq, notify;
  logic [15:0] n_peer;
  logic [7:0]  n_vec;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbox_doorbell_regs #(.NUM_PEERS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .pos_i(pos),
    .event_i(ev), .irq_o(irq), .cfg_we_i(cfg_we), .cfg_peer_i(cfg_peer),
    .cfg_count_i(cfg_cnt), .notify_o(notify), .notify_peer_o(n_peer),
    .notify_vec_o(n_vec)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    d = rdata;
    chk(rvalid == 1'b1, "R2 rvalid", 32'(rvalid), 32'd1);
  endtask

  function automatic int cnt_of(input int p);
    return (p * 2) % 5;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(notify == 0, "R1 notify", 32'(notify), 0);
    rd(8'h00, v); chk(v == 0, "R1 mask", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 status", v, 0);
    // R11 empty table drops everything
    wr(8'h0C, 32'h0000_0000);
    chk(notify == 0, "R11 empty table", 32'(notify), 0);

    for (int p = 0; p < NP; p++) begin
      @(negedge clk); cfg_we = 1; cfg_peer = 2'(p); cfg_cnt = 9'(cnt_of(p));
    end
    @(negedge clk); cfg_we = 0;

    // R2
    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'h00, v); chk(v == 32'hDEAD_BEEF, "R2 mask rw", v, 32'hDEAD_BEEF);
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, v); chk(v == 32'h1234_5678, "R2 status rw", v, 32'h1234_5678);
    // R6
    rd(8'h04, v); chk(v == 0, "R6 read clears", v, 0);
    rd(8'h08, v); chk(v == 32'h0000_00A7, "R2 position", v, 32'hA7);
    // R3
    wr(8'h03, 32'h0000_0F0F);
    rd(8'h00, v); chk(v == 32'h0000_0F0F, "R3 write 0x03 to mask", v, 32'hF0F);
    wr(8'h06, 32'h0000_00F0);
    // R8
    chk(irq == 0, "R8 disjoint bits", 32'(irq), 0);
    wr(8'h00, 32'h0000_0010);
    chk(irq == 1, "R8 overlap", 32'(irq), 1);
    wr(8'h00, 32'h0);
    chk(irq == 0, "R8 mask zero", 32'(irq), 0);
    wr(8'h00, 32'h0000_00FF);
    // R4
    rd(8'h01, v); chk(v == 0, "R4 unaligned read 0x01", v, 0);
    rd(8'h0C, v); chk(v == 0, "R4 doorbell read", v, 0);
    rd(8'h40, v); chk(v == 0, "R4 empty offset read", v, 0);
    rd(8'h05, v); chk(v == 0, "R4 unaligned read 0x05", v, 0);
    chk(irq == 1, "R4 status kept after 0x05", 32'(irq), 1);
    // R5
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == 32'h0000_00FF, "R5 mask unchanged", v, 32'hFF);
    rd(8'h04, v); chk(v == 32'h0000_00F0, "R5 status unchanged", v, 32'hF0);
    // R7 overwrite with 1
    wr(8'h04, 32'hFF00_FF00);
    @(negedge clk); ev = 1; @(negedge clk); ev = 0;
    rd(8'h04, v); chk(v == 1, "R7 event sets 1", v, 1);
    @(negedge clk); req = 1; we = 1; addr = 8'h04; wdata = 32'hABCD; ev = 1;
    @(negedge clk); req = 0; we = 0; ev = 0;
    rd(8'h04, v); chk(v == 1, "R7 event beats write", v, 1);
    wr(8'h04, 32'h0000_0055);
    @(negedge clk); req = 1; we = 0; addr = 8'h04; ev = 1;
    @(negedge clk); req = 0; ev = 0;
    chk(rdata == 32'h55, "R7 read returns old", rdata, 32'h55);
    rd(8'h04, v); chk(v == 1, "R7 event beats clear", v, 1);

    // R9 R10 R11 sweep
    for (int p = 0; p < NP + 2; p++) begin
      for (int vv = 0; vv < 6; vv++) begin
        logic [7:0] fill;
        bit exp;
        fill = 8'((p * 37 + vv * 11) & 8'hFF);
        exp = (p < NP) && (vv < cnt_of(p));
        wr(8'h0C, {16'(p), fill, 8'(vv)});
        chk(notify == exp, exp ? "R9 legal doorbell" : (p >= NP ? "R10 peer range" : "R11 vector range"),
            32'(notify), 32'(exp));
        if (exp) begin
          chk(n_peer == 16'(p) && n_vec == 8'(vv), "R9 notify fields",
              {n_peer, 8'h0, n_vec}, {16'(p), 8'h0, 8'(vv)});
        end
        @(negedge clk);
        chk(notify == 0, "R9 single cycle", 32'(notify), 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule